// File: doc/BRIEF.md
# Bridge Driver Fault Supervisor

This block gathers the digital fault flags of a four-bridge motor power stage and decides when the bridges and the gate-drive charge pump must be switched off. An overcurrent on any bridge only counts once it has persisted for a programmable qualification window. After that it switches every bridge off, and the shutdown holds until the supply is cycled. An over-temperature flag also switches the bridges off and holds until the supply is cycled, but a supply-cycle event cannot clear it while the die is still hot. A supply-undervoltage flag shuts everything down, including the charge pump. It asks for the command registers to be returned to their initial state, and it releases on its own once the flag drops.

The chip-level reset pin and the sleep pin act as direct gates on the outputs. Neither one touches the latched faults. A dedicated power-on input stands in for the supply-cycle event. All asynchronous inputs pass a two-stage synchronizer before any decision is made. The internal reset is asserted asynchronously and released synchronously.

Top module: `bridge_fault_guard`

## Requirements
- R1: If any `oc_limit` bit is high on QUAL_CYCLES consecutive rising edges, `ocp_fault` and `drv_off` go high two cycles after the last of those edges. If the run is QUAL_CYCLES-1 edges long, no fault is raised.
- R2: The persistence count restarts whenever every `oc_limit` bit is low for one cycle. Moving the flag from one bridge to another with no gap keeps the count running.
- R3: `ocp_fault` stays high after the flags drop, and while the reset pin or the sleep pin is active. Only a `power_on` pulse clears it.
- R4: `over_temp` high sets `therm_fault` and `drv_off`. A `power_on` pulse clears `therm_fault` only if `over_temp` is low when the pulse is sampled.
- R5: While `supply_low` is high, `drv_off`, `pump_off`, `cmd_reset` and `uv_now` are high. All four return low once `supply_low` drops, and nothing is latched.
- R6: `reset_pin_n` low drives `drv_off`, `pump_off` and `cmd_reset` high.
- R7: `sleep_pin_n` low drives `drv_off` and `pump_off` high while `cmd_reset` stays low. On release the outputs return to the state that the latched faults dictate.
- R8: If a `power_on` pulse is sampled on the same edge that completes overcurrent qualification, the fault is latched (the set takes priority).
- R9: While `rst_n` is low, `drv_off`, `pump_off` and `cmd_reset` are high and both latched faults are low. Each input affects the outputs only after two synchronizer edges.
- R10: Latched overcurrent or thermal faults leave `pump_off` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_limit | input | NUM_BRIDGES | Per-bridge analog current-limit flags |
| over_temp | input | 1 | Die over-temperature flag |
| supply_low | input | 1 | Motor supply undervoltage flag |
| reset_pin_n | input | 1 | Active-low chip reset pin |
| sleep_pin_n | input | 1 | Active-low sleep pin |
| power_on | input | 1 | Supply-cycle (power-on) event |
| drv_off | output | 1 | Disable all bridges |
| pump_off | output | 1 | Disable the gate-drive charge pump |
| cmd_reset | output | 1 | Request to return command registers to initial state |
| ocp_fault | output | 1 | Latched overcurrent shutdown |
| therm_fault | output | 1 | Latched thermal shutdown |
| uv_now | output | 1 | Undervoltage currently present |

## Verification
The overcurrent qualification and the power-on clear can land on the same edge and drive the same latch in opposite directions. The bench provokes this by raising `power_on` for exactly one cycle, timed so that its synchronized copy reaches the latch on the edge where the persistence count completes. The case passes only if `ocp_fault` and `drv_off` are high afterwards. A second collision, a power-on pulse while `over_temp` is still high, is judged by `therm_fault` staying set.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

  localparam int unsigned SYNC_STAGES = 2;

  // Synchronized view of the supervisor inputs
  typedef struct packed {
    logic oc_any;
    logic hot;
    logic uv;
    logic rpin_n;
    logic slp_n;
    logic pwr;
  } guard_in_t;

endpackage

// File: rtl/fg_reset_sync.sv
module fg_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/fg_sync_bank.sv
module fg_sync_bank #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/fg_oc_qualifier.sv
module fg_oc_qualifier #(
  parameter int unsigned QUAL_CYCLES = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_any,
  output logic trip
);

  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign trip   = oc_any && (cnt_q == LAST);
  assign cnt_en = !oc_any || (cnt_q != LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!oc_any)             cnt_d = '0;
    else if (cnt_q != LAST)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: a cycle with no overcurrent restarts the persistence count
  p_count_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_any |=> (cnt_q == '0));

  // R1: a trip can only start after overcurrent was already present
  p_trip_persist_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> $past(oc_any));

endmodule

// File: rtl/fg_fault_latch.sv
module fg_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_d;

  always_comb begin
    flag_d = flag_o;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_d;
  end

  // R8: a set request wins over a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

endmodule

// File: rtl/bridge_fault_guard.sv
module bridge_fault_guard #(
  parameter int unsigned NUM_BRIDGES = 4,
  parameter int unsigned QUAL_CYCLES = 750
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_BRIDGES-1:0] oc_limit,
  input  logic                   over_temp,
  input  logic                   supply_low,
  input  logic                   reset_pin_n,
  input  logic                   sleep_pin_n,
  input  logic                   power_on,
  output logic                   drv_off,
  output logic                   pump_off,
  output logic                   cmd_reset,
  output logic                   ocp_fault,
  output logic                   therm_fault,
  output logic                   uv_now
);

  import fault_guard_pkg::*;

  localparam int unsigned SW = NUM_BRIDGES + 5;

  logic          srst_n;
  logic [SW-1:0] raw_in;
  logic [SW-1:0] syn_in;
  guard_in_t     gi;
  logic          oc_trip;
  logic          gate_off;

  fg_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign raw_in = {power_on, sleep_pin_n, reset_pin_n, supply_low, over_temp, oc_limit};

  fg_sync_bank #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  always_comb begin
    gi.oc_any = |syn_in[NUM_BRIDGES-1:0];
    gi.hot    = syn_in[NUM_BRIDGES];
    gi.uv     = syn_in[NUM_BRIDGES+1];
    gi.rpin_n = syn_in[NUM_BRIDGES+2];
    gi.slp_n  = syn_in[NUM_BRIDGES+3];
    gi.pwr    = syn_in[NUM_BRIDGES+4];
  end

  fg_oc_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk    (clk),
    .rst_n  (srst_n),
    .oc_any (gi.oc_any),
    .trip   (oc_trip)
  );

  fg_fault_latch u_ocp_latch (
    .clk    (clk),
    .rst_n  (srst_n),
    .set_i  (oc_trip),
    .clr_i  (gi.pwr),
    .flag_o (ocp_fault)
  );

  fg_fault_latch u_hot_latch (
    .clk    (clk),
    .rst_n  (srst_n),
    .set_i  (gi.hot),
    .clr_i  (gi.pwr && !gi.hot),
    .flag_o (therm_fault)
  );

  assign gate_off  = !gi.rpin_n || !gi.slp_n || gi.uv;
  assign drv_off   = gate_off || ocp_fault || therm_fault;
  assign pump_off  = gate_off;
  assign cmd_reset = gi.uv || !gi.rpin_n;
  assign uv_now    = gi.uv;

  // R3: overcurrent shutdown holds until a power-on event
  p_ocp_hold_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (ocp_fault && !gi.pwr) |=> ocp_fault);

  // R4: thermal shutdown cannot clear while the die is hot
  p_hot_hold_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (therm_fault && gi.hot) |=> therm_fault);

  // R5: undervoltage shuts down drivers and pump and resets commands
  p_uv_shutdown_r5: assert property (@(posedge clk) disable iff (!srst_n)
    gi.uv |-> (drv_off && pump_off && cmd_reset));

  // R7: sleep alone never requests a command reset
  p_sleep_no_reset_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (!gi.slp_n && gi.rpin_n && !gi.uv) |-> (!cmd_reset && pump_off));

  // R10: latched faults leave the charge pump running
  p_pump_free_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (gi.rpin_n && gi.slp_n && !gi.uv) |-> !pump_off);

endmodule

// File: tb/bridge_fault_guard_bench.sv
module bridge_fault_guard_bench;

  localparam int unsigned NB = 4;
  localparam int unsigned Q  = 750;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NB-1:0] oc_limit;
  logic          over_temp, supply_low, reset_pin_n, sleep_pin_n, power_on;
  logic          drv_off, pump_off, cmd_reset, ocp_fault, therm_fault, uv_now;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bridge_fault_guard #(.NUM_BRIDGES(NB), .QUAL_CYCLES(Q)) u_bridge_fault_guard (
    .clk, .rst_n, .oc_limit, .over_temp, .supply_low, .reset_pin_n,
    .sleep_pin_n, .power_on, .drv_off, .pump_off, .cmd_reset,
    .ocp_fault, .therm_fault, .uv_now
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // expected order: {drv_off, pump_off, cmd_reset, ocp_fault, therm_fault, uv_now}
  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {drv_off, pump_off, cmd_reset, ocp_fault, therm_fault, uv_now};
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_pwr();
    power_on = 1'b1; tick(1); power_on = 1'b0; tick(3);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; oc_limit = '0; over_temp = 0; supply_low = 0;
    reset_pin_n = 1; sleep_pin_n = 1; power_on = 0;
    tick(3);
    check("R9 in reset", 6'b111000);
    rst_n = 1'b1;
    tick(6);
    check("R9 after release", 6'b000000);
  endtask

  task automatic t_oc_short();
    oc_limit = 4'b0001; tick(Q-1); oc_limit = '0; tick(2);
    check("R1 short run", 6'b000000);
    tick(5);
    check("R1 short run later", 6'b000000);
  endtask

  task automatic t_oc_trip();
    oc_limit = 4'b1000; tick(Q); oc_limit = '0; tick(2);
    check("R1 qualified trip", 6'b100100);
    tick(20);
    check("R3 latched after flag drop", 6'b100100);
    pulse_pwr();
    check("R3 power-on clears", 6'b000000);
  endtask

  task automatic t_oc_gap();
    oc_limit = 4'b0001; tick(Q-1); oc_limit = '0; tick(1);
    oc_limit = 4'b0001; tick(Q-1); oc_limit = '0; tick(3);
    check("R2 gap restarts count", 6'b000000);
  endtask

  task automatic t_oc_handoff();
    oc_limit = 4'b0010; tick(Q/2); oc_limit = 4'b0100; tick(Q - Q/2);
    oc_limit = '0; tick(2);
    check("R2 handoff keeps count", 6'b100100);
    pulse_pwr();
  endtask

  task automatic t_pins_with_fault();
    oc_limit = 4'b0001; tick(Q); oc_limit = '0; tick(2);
    reset_pin_n = 0; tick(2);
    check("R6 reset pin low", 6'b111100);
    reset_pin_n = 1; tick(2);
    check("R3 survives reset pin", 6'b100100);
    sleep_pin_n = 0; tick(2);
    check("R7 sleep low", 6'b110100);
    sleep_pin_n = 1; tick(2);
    check("R10 pump on with fault", 6'b100100);
    pulse_pwr();
    check("R3 cleared after pins", 6'b000000);
  endtask

  task automatic t_sleep_only();
    sleep_pin_n = 0; tick(2);
    check("R7 sleep alone", 6'b110000);
    sleep_pin_n = 1; tick(2);
    check("R7 sleep release", 6'b000000);
  endtask

  task automatic t_thermal();
    over_temp = 1; tick(3);
    check("R4 thermal set", 6'b100010);
    pulse_pwr();
    check("R4 no clear while hot", 6'b100010);
    over_temp = 0; tick(3);
    check("R4 latched after cool", 6'b100010);
    pulse_pwr();
    check("R4 clear when cool", 6'b000000);
  endtask

  task automatic t_uv();
    supply_low = 1; tick(1);
    check("R9 not yet synced", 6'b000000);
    tick(1);
    check("R5 undervoltage", 6'b111001);
    supply_low = 0; tick(2);
    check("R5 self recovery", 6'b000000);
  endtask

  task automatic t_coincide();
    oc_limit = 4'b0001; tick(Q-1);
    power_on = 1; tick(1);
    power_on = 0; oc_limit = '0; tick(2);
    check("R8 set wins over power-on", 6'b100100);
    pulse_pwr();
    check("R8 later clear", 6'b000000);
  endtask

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_oc_short();
    t_oc_trip();
    t_oc_gap();
    t_oc_handoff();
    t_pins_with_fault();
    t_sleep_only();
    t_thermal();
    t_uv();
    t_coincide();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule